// File: doc/BRIEF.md
# SDRAM Halfword Write Burst Sequencer

This block turns one host write request into a complete write access on a 16-bit SDRAM whose row address, column address and data all travel on one shared AD bus. A request carries a packed row/column start address and a halfword count. The block then waits until the host's write-data stream is ready. After that it issues an Activate with the row and fills the CAS-latency gap with NOPs. Next comes a Write command that carries the column address less one with both byte masks high, so that first slot is a dummy write. One halfword per clock follows with the masks low, a Burst Terminate closes the burst, and a deselected gap ends the access before the next one may start.

The host presents write data through a valid/ready stream. The sequencer commits to a burst only once data is valid, so a slow producer delays the Activate and never a data slot. Once valid has been seen, the producer must keep data flowing for the whole count. Every SDRAM pin comes from a register.

Top module: `sdram_hw_writer`

## Requirements
- R1: While reset is held, sd_cke is low. Out of reset, the block idles with sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n high, sd_dqm = 2'b11, sd_ad = 0, busy low and req_ready high.
- R2: A request is taken on a clock where req_valid and req_ready are both high. The upper ROW_W bits of req_addr are the row and the lower COL_W bits are the column. req_len holds the halfword count minus one, so n = req_len + 1. From the next clock on, busy is high and req_ready is low.
- R3: No command is issued until wr_valid has been seen high after the request is taken. The first command is then Activate, {cs_n,ras_n,cas_n,we_n} = 4'b0011, with the row zero-extended on sd_ad.
- R4: The Activate is followed by CAS_LAT-1 NOP cycles (4'b0111) and then a Write command (4'b0100).
- R5: In the Write cycle, sd_ad carries (column - 1) modulo 2^COL_W, zero-extended, so column 0 wraps to all ones. sd_dqm is 2'b11 in that cycle.
- R6: The n cycles after the Write carry the NOP command with sd_dqm = 2'b00. The halfword accepted in data slot k appears on sd_ad in slot k. wr_ready is high for exactly n clocks, and those clocks are aligned to the data slots.
- R7: The cycle after the last data slot carries Burst Terminate (4'b0110) with sd_dqm = 2'b11.
- R8: After Burst Terminate, sd_cs_n stays high for at least GAP_CYC cycles. busy falls exactly GAP_CYC clocks after the Burst Terminate cycle is visible at the pins.
- R9: A request raised while busy is high is not taken and causes no later access.
- R10: sd_cke is high in every cycle in which sd_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ROW_W+COL_W | Start address, row in the upper bits |
| req_len | input | LEN_W | Halfword count minus one |
| wr_valid | input | 1 | Write-data halfword available |
| wr_ready | output | 1 | Halfword consumed this clock |
| wr_data | input | DQ_W | Write-data halfword |
| busy | output | 1 | Access in progress, including the idle gap |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 2 | Byte masks, bit 1 upper and bit 0 lower, high masks the byte |
| sd_ad | output | DQ_W | Shared address/data bus |

## Verification
The hardest cases to reach from the ports are the column wrap in the dummy Write slot and a producer that is late with data while a request is already pending. The bench sweeps every burst length of a 3-bit count against columns 0, 1, an interior value and the top column, so the minus-one wrap and the single-halfword burst both occur. It also holds wr_valid low for zero to two clocks after each request is taken, to show that the Activate waits for the stream. One burst keeps a second request raised through its data phase and drops it during the gap, to show that it is never taken.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITD,
    ST_ACT,
    ST_NOP,
    ST_WCMD,
    ST_DATA,
    ST_BTERM,
    ST_GAP
  } wr_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_BTERM = 4'b0110;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_DESEL = 4'b1111;

  localparam logic [1:0] MASK_ALL  = 2'b11;
  localparam logic [1:0] MASK_NONE = 2'b00;

endpackage

// File: rtl/sdram_wr_req_latch.sv
module sdram_wr_req_latch #(
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int LEN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [LEN_W-1:0]       len,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic [LEN_W-1:0]       len_m1
);

  localparam int ADDR_W = ROW_W + COL_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row    <= '0;
      col    <= '0;
      len_m1 <= '0;
    end else if (take) begin
      row    <= addr[ADDR_W-1:COL_W];
      col    <= addr[COL_W-1:0];
      len_m1 <= len;
    end
  end

endmodule

// File: rtl/sdram_wr_ctrl.sv
module sdram_wr_ctrl
  import sdram_wr_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int CAS_LAT = 2,
  parameter int GAP_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             wr_valid,
  input  logic [LEN_W-1:0] len_m1,
  output wr_state_e        state,
  output logic             req_take,
  output logic             req_ready,
  output logic             busy,
  output logic             wr_ready
);

  localparam int SMALL_W = $clog2(CAS_LAT + GAP_CYC + 1);
  localparam int CNT_W   = (LEN_W > SMALL_W) ? LEN_W : SMALL_W;

  wr_state_e        st, st_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  // named internal events
  logic cnt_zero;
  logic commit_evt;
  logic last_beat;
  logic gap_done;

  assign cnt_zero   = (cnt == '0);
  assign commit_evt = (st == ST_WAITD) && wr_valid;
  assign last_beat  = (st == ST_DATA) && cnt_zero;
  assign gap_done   = (st == ST_GAP) && cnt_zero;

  assign req_ready = (st == ST_IDLE);
  assign req_take  = req_valid && req_ready;
  assign busy      = (st != ST_IDLE);
  assign wr_ready  = (st == ST_DATA);
  assign state     = st;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    unique case (st)
      ST_IDLE:  if (req_take) st_nxt = ST_WAITD;
      ST_WAITD: if (commit_evt) st_nxt = ST_ACT;
      ST_ACT: begin
        if (CAS_LAT > 1) begin
          st_nxt  = ST_NOP;
          cnt_nxt = CNT_W'(CAS_LAT - 2);
        end else begin
          st_nxt = ST_WCMD;
        end
      end
      ST_NOP: begin
        if (cnt_zero) st_nxt = ST_WCMD;
        else          cnt_nxt = cnt - 1'b1;
      end
      ST_WCMD: begin
        st_nxt  = ST_DATA;
        cnt_nxt = CNT_W'(len_m1);
      end
      ST_DATA: begin
        if (last_beat) st_nxt = ST_BTERM;
        else           cnt_nxt = cnt - 1'b1;
      end
      ST_BTERM: begin
        st_nxt  = ST_GAP;
        cnt_nxt = CNT_W'(GAP_CYC - 1);
      end
      ST_GAP: begin
        if (gap_done) st_nxt = ST_IDLE;
        else          cnt_nxt = cnt - 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> (busy && !req_ready));

  // R6
  stream_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> wr_valid);

  // R3
  commit_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_WAITD && st == ST_ACT) |-> $past(wr_valid));

endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
  import sdram_wr_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int DQ_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_state_e        state,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [DQ_W-1:0]  wr_data,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [1:0]       sd_dqm,
  output logic [DQ_W-1:0]  sd_ad
);

  function automatic logic [DQ_W-1:0] row_word(input logic [ROW_W-1:0] r);
    return DQ_W'(r);
  endfunction

  // column placed one below the first data address: the first slot is a dummy
  function automatic logic [DQ_W-1:0] write_col_word(input logic [COL_W-1:0] c);
    logic [COL_W-1:0] d;
    d = c - 1'b1;
    return DQ_W'(d);
  endfunction

  logic [3:0]      cmd_d, cmd_q;
  logic [1:0]      dqm_d, dqm_q;
  logic [DQ_W-1:0] ad_d, ad_q;
  logic            cke_q;

  always_comb begin
    cmd_d = CMD_DESEL;
    dqm_d = MASK_ALL;
    ad_d  = '0;
    unique case (state)
      ST_ACT: begin
        cmd_d = CMD_ACT;
        ad_d  = row_word(row);
      end
      ST_NOP:  cmd_d = CMD_NOP;
      ST_WCMD: begin
        cmd_d = CMD_WRITE;
        ad_d  = write_col_word(col);
      end
      ST_DATA: begin
        cmd_d = CMD_NOP;
        dqm_d = MASK_NONE;
        ad_d  = wr_data;
      end
      ST_BTERM: cmd_d = CMD_BTERM;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_DESEL;
      dqm_q <= MASK_ALL;
      ad_q  <= '0;
      cke_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      dqm_q <= dqm_d;
      ad_q  <= ad_d;
      cke_q <= 1'b1;
    end
  end

  assign sd_cke   = cke_q;
  assign sd_cs_n  = cmd_q[3];
  assign sd_ras_n = cmd_q[2];
  assign sd_cas_n = cmd_q[1];
  assign sd_we_n  = cmd_q[0];
  assign sd_dqm   = dqm_q;
  assign sd_ad    = ad_q;

  // R10
  cke_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> sd_cke);

  // R4
  write_after_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WRITE) |-> ($past(cmd_q) == CMD_NOP || $past(cmd_q) == CMD_ACT));

  // R5
  write_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WRITE) |-> (dqm_q == MASK_ALL));

  // R6
  data_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm_q == MASK_NONE) |-> ($past(cmd_q) == CMD_WRITE || $past(dqm_q) == MASK_NONE));

  // R7
  bterm_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_BTERM) |-> ($past(dqm_q) == MASK_NONE && dqm_q == MASK_ALL));

  // R8
  desel_after_bterm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_BTERM) |=> sd_cs_n);

  // R3
  act_after_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> $past(sd_cs_n));

endmodule

// File: rtl/sdram_hw_writer.sv
module sdram_hw_writer
  import sdram_wr_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int LEN_W   = 8,
  parameter int DQ_W    = 16,
  parameter int CAS_LAT = 2,
  parameter int GAP_CYC = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [DQ_W-1:0]        wr_data,
  output logic                   busy,
  output logic                   sd_cke,
  output logic                   sd_cs_n,
  output logic                   sd_ras_n,
  output logic                   sd_cas_n,
  output logic                   sd_we_n,
  output logic [1:0]             sd_dqm,
  output logic [DQ_W-1:0]        sd_ad
);

  wr_state_e        state;
  logic             req_take;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [LEN_W-1:0] len_m1;

  sdram_wr_req_latch #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (req_take),
    .addr   (req_addr),
    .len    (req_len),
    .row    (row),
    .col    (col),
    .len_m1 (len_m1)
  );

  sdram_wr_ctrl #(
    .LEN_W(LEN_W), .CAS_LAT(CAS_LAT), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .wr_valid  (wr_valid),
    .len_m1    (len_m1),
    .state     (state),
    .req_take  (req_take),
    .req_ready (req_ready),
    .busy      (busy),
    .wr_ready  (wr_ready)
  );

  sdram_wr_pins #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .row      (row),
    .col      (col),
    .wr_data  (wr_data),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_dqm   (sd_dqm),
    .sd_ad    (sd_ad)
  );

  // R9
  no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_take);

endmodule

// File: tb/sdram_hw_writer_test.sv
module sdram_hw_writer_test;

  localparam int CLK_P   = 10;
  localparam int ROW_W   = 13;
  localparam int COL_W   = 9;
  localparam int LEN_W   = 3;
  localparam int DQ_W    = 16;
  localparam int CAS_LAT = 2;
  localparam int GAP_CYC = 2;
  localparam int COL_SPAN = 1 << COL_W;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   req_valid = 1'b0;
  logic                   req_ready;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]       req_len = '0;
  logic                   wr_valid = 1'b0;
  logic                   wr_ready;
  logic [DQ_W-1:0]        wr_data = '0;
  logic                   busy;
  logic                   sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]             sd_dqm;
  logic [DQ_W-1:0]        sd_ad;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  sdram_hw_writer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .DQ_W(DQ_W),
    .CAS_LAT(CAS_LAT), .GAP_CYC(GAP_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .busy(busy), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_ad(sd_ad)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [3:0] pin_cmd();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic logic [DQ_W-1:0] beat_word(int row, int col, int k, int n);
    return DQ_W'(row * 31 + col * 7 + k * 257 + n * 4099);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic do_write(input int row, input int col, input int n, input int stall,
                          input bit intrude);
    int  exp_col;
    bit  found;
    found = 1'b0;
    exp_col = (col + COL_SPAN - 1) % COL_SPAN;
    // R2: accept
    req_addr  = (ROW_W+COL_W)'(row * COL_SPAN + col);
    req_len   = LEN_W'(n - 1);
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready before take", req_ready, 1);
    step();
    req_valid = 1'b0;
    chk(busy == 1'b1 && req_ready == 1'b0, "R2 busy after take", {busy, req_ready}, 2'b10);
    // R3: no command while the stream is not valid
    for (int s = 0; s < stall; s++) begin
      chk(sd_cs_n == 1'b1, "R3 idle while data absent", sd_cs_n, 1);
      step();
    end
    wr_valid = 1'b1;
    wr_data  = beat_word(row, col, 0, n);
    for (int t = 0; t < 8 && !found; t++) begin
      step();
      if (pin_cmd() == 4'b0011) found = 1'b1;
      else chk(sd_cs_n == 1'b1, "R3 deselect before activate", sd_cs_n, 1);
    end
    chk(found, "R3 activate seen", found, 1);
    chk(sd_ad == DQ_W'(row), "R3 row on bus", sd_ad, row);
    chk(sd_cke == 1'b1, "R10 cke with cs low", sd_cke, 1);
    // R4
    for (int j = 1; j < CAS_LAT; j++) begin
      step();
      chk(pin_cmd() == 4'b0111, "R4 nop gap", pin_cmd(), 4'b0111);
      chk(wr_ready == 1'b0, "R6 ready idle before write", wr_ready, 0);
    end
    step();
    chk(pin_cmd() == 4'b0100, "R4 write command", pin_cmd(), 4'b0100);
    // R5
    chk(sd_ad == DQ_W'(exp_col), "R5 dummy column", sd_ad, exp_col);
    chk(sd_dqm == 2'b11, "R5 masks high on write", sd_dqm, 2'b11);
    // R6
    for (int k = 0; k < n; k++) begin
      wr_data = beat_word(row, col, k, n);
      chk(wr_ready == 1'b1, "R6 ready in slot", wr_ready, 1);
      if (intrude) begin
        req_valid = 1'b1;
        req_addr  = '1;
        chk(req_ready == 1'b0, "R9 not ready while busy", req_ready, 0);
      end
      step();
      chk(pin_cmd() == 4'b0111 && sd_dqm == 2'b00, "R6 data slot command",
          {pin_cmd(), sd_dqm}, {4'b0111, 2'b00});
      chk(sd_ad == beat_word(row, col, k, n), "R6 data word", sd_ad, beat_word(row, col, k, n));
    end
    chk(wr_ready == 1'b0, "R6 ready drops after n", wr_ready, 0);
    wr_valid = 1'b0;
    step();
    // R7
    chk(pin_cmd() == 4'b0110 && sd_dqm == 2'b11, "R7 burst terminate",
        {pin_cmd(), sd_dqm}, {4'b0110, 2'b11});
    chk(busy == 1'b1, "R8 busy at terminate", busy, 1);
    req_valid = 1'b0;
    // R8
    for (int i = 1; i <= GAP_CYC; i++) begin
      step();
      chk(sd_cs_n == 1'b1, "R8 gap deselect", sd_cs_n, 1);
      chk(busy == (i < GAP_CYC), "R8 busy timing", busy, (i < GAP_CYC));
    end
    chk(req_ready == 1'b1, "R8 ready after gap", req_ready, 1);
    if (intrude) begin
      for (int i = 0; i < 4; i++) begin
        step();
        chk(sd_cs_n == 1'b1 && busy == 1'b0, "R9 stale request ignored",
            {sd_cs_n, busy}, 2'b10);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "watchdog", cycles, 100000);
        summary();
      end
    end
  end

  initial begin
    int cols[4];
    cols = '{0, 1, 37, COL_SPAN - 1};
    @(negedge clk);
    // R1
    chk(sd_cke == 1'b0, "R1 cke low in reset", sd_cke, 0);
    step();
    rst_n = 1'b1;
    step();
    chk(pin_cmd() == 4'b1111, "R1 idle command", pin_cmd(), 4'b1111);
    chk(sd_dqm == 2'b11 && sd_ad == '0, "R1 idle bus", {sd_dqm, sd_ad}, {2'b11, 16'h0});
    chk(busy == 1'b0 && req_ready == 1'b1, "R1 idle handshake", {busy, req_ready}, 2'b01);
    chk(sd_cke == 1'b1, "R1 cke after reset", sd_cke, 1);
    for (int n = 1; n <= (1 << LEN_W); n++) begin
      for (int ci = 0; ci < 4; ci++) begin
        do_write(n * 613 + ci * 97, cols[ci], n, (n + ci) % 3, 1'b0);
        step();
      end
    end
    do_write(4095, 0, 3, 1, 1'b1);
    do_write(8191, COL_SPAN - 1, 1, 0, 1'b0);
    summary();
  end

endmodule